// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter Pair

The block holds two 16-bit timer/counter channels, A and B, behind a small word-addressed register bus. Each channel has a control register, a write-only command register, a reload register and a readable count. A channel either steps once per module clock (timer mode) or steps on qualified events of its own external input (counter mode). It counts up or down. When the count passes its end value the channel raises a pending flag and reloads. In one-shot mode it also stops.

Setting the cascade bit in channel A's control register joins the two channels into one 32-bit down/up timer. A holds the low half and B the high half. Only channel A's configuration, commands and pending flag take part in that mode. Each channel's pending flag is gated by its own interrupt enable to form an interrupt line. The flags are cleared by writing ones to the status register.

Top module: `timer_pair`

## Requirements
- R1: After reset every register reads 0, both counts are 0, no channel runs and irq_o is 0.
- R2: Word addresses: 0/1 control A/B, 2/3 command A/B, 4/5 reload A/B, 6/7 count A/B, 8 interrupt enable (bit 0 = A, bit 1 = B), 9 pending status (same bits). Control bit 0 reads 1 while the channel runs, and writes to it are ignored. Command and count registers read as 0 and ignore writes, respectively.
- R3: In timer mode (control bit 2 = 0, bit 9 = 0) a running channel steps once per clock edge: down when control bit 1 = 0, up when it is 1.
- R4: Command bit 1 stops the channel and wins over bit 0, which starts it. A start with bit 2 set first loads the count from the reload register. A start without bit 2 resumes from the held count, and a stopped count never changes.
- R5: A down step taken at count 0, or an up step taken at count 0xFFFF, is a wrap. A wrap loads the reload value instead and sets the channel's pending flag; in cyclic mode (control bit 3 = 0) the channel keeps running.
- R6: With control bit 3 = 1 the channel stops at its first wrap and holds the reload value.
- R7: In counter mode (control bit 2 = 1) control bits 7:6 choose the step: 0 = every clock the input is high, 1 = rising edge, 2 = falling edge, 3 = both edges. Each edge gives exactly one step.
- R8: Control bit 5 inverts the input before edge detection. With control bit 8 = 1 the input passes a two-stage synchronizer and a change is counted two edges later than with bit 8 = 0, where it is counted at the first edge.
- R9: In timer mode with control bit 9 = 1 the channel steps on rising edges of its conditioned external input instead of every clock.
- R10: Control bit 4 exists only on channel A and reads 0 on B. When set, {B,A} is one 32-bit counter using A's configuration and commands with reload {reload B, reload A}. Command writes to B are ignored, a wrap occurs only at the 32-bit end value and sets only A's pending flag.
- R11: irq_o[c] is pending[c] AND enable[c]. Writing 1 to a status bit clears it, writing 0 leaves it, and a wrap in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ext_i | input | 2 | External event/clock inputs, bit 0 for A, bit 1 for B |
| irq_o | output | 2 | Interrupt lines, bit 0 for A, bit 1 for B |

## Verification
Register writes take effect at the clock edge that samples wr_i. A running internal-clock timer moves one step at that same edge and at each edge after it. Count and status reads are combinational, so the value after n edges is visible straight after the n-th edge. An unsynchronized input level is counted at the next edge, and the synchronizer adds two more edges. The bench drives every input and samples every output at the falling clock edge. It works out its expected counts from the number of rising edges that have passed, for example reload minus steps modulo the wrap period. That includes the extra step that a stop command costs while the channel is still running.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_FALL  = 2'd2,
    EV_BOTH  = 2'd3
  } ev_sel_e;

  // control register bits 9:1, bit 0 is the running flag
  typedef struct packed {
    logic    src_ext;
    logic    sync_en;
    ev_sel_e ev_sel;
    logic    inv;
    logic    chain;
    logic    one_shot;
    logic    cnt_mode;
    logic    up;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  localparam int unsigned ADR_CTL = 0;
  localparam int unsigned ADR_RUN = 2;
  localparam int unsigned ADR_RLD = 4;
  localparam int unsigned ADR_CNT = 6;
  localparam int unsigned ADR_IEN = 8;
  localparam int unsigned ADR_IST = 9;

  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_STOP  = 1;
  localparam int unsigned CMD_LOAD  = 2;

endpackage

// File: rtl/timer_pair_evt.sv
module timer_pair_evt
  import timer_pair_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pin_i,
  input  logic    inv_i,
  input  logic    sync_en_i,
  input  ev_sel_e sel_i,
  output logic    ev_o,
  output logic    rise_o
);

  logic                   raw;
  logic                   cur;
  logic                   prev_q;
  logic                   fall;
  logic [SYNC_STAGES-1:0] sync_q;

  assign raw = pin_i ^ inv_i;
  assign cur = sync_en_i ? sync_q[SYNC_STAGES-1] : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      prev_q <= cur;
    end
  end

  assign rise_o = cur & ~prev_q;
  assign fall   = ~cur & prev_q;

  always_comb begin
    unique case (sel_i)
      EV_LEVEL: ev_o = cur;
      EV_RISE:  ev_o = rise_o;
      EV_FALL:  ev_o = fall;
      default:  ev_o = rise_o | fall;
    endcase
  end

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7

endmodule

// File: rtl/timer_pair_cnt.sv
module timer_pair_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         end_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= ld_val_i;
    else if (step_i) cnt_q <= up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  assign cnt_o = cnt_q;
  assign end_o = up_i ? &cnt_q : ~|cnt_q;

endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import timer_pair_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        ext_i,
  output logic [1:0]        irq_o
);

  localparam int unsigned N_CH = 2;

  ctl_t             ctl_q   [N_CH];
  ctl_t             ctl_nv  [N_CH];
  logic [CNT_W-1:0] rld_q   [N_CH];
  logic [N_CH-1:0]  run_q, ien_q, pend_q;

  logic [N_CH-1:0][CNT_W-1:0] cnt;
  logic [N_CH-1:0]  at_end, ev_in, rise_in, tick, step, load, wrap, up_eff;
  logic [N_CH-1:0]  wr_ctl, wr_rld, run_wr, start, stop, start_ld, pend_clr;
  logic             wr_ien, wr_ist, chain;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign chain        = ctl_q[0].chain;

  // bus decode and command strobes
  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      wr_ctl[c] = wr_i && (addr_i == ADDR_W'(ADR_CTL + c));
      wr_rld[c] = wr_i && (addr_i == ADDR_W'(ADR_RLD + c));
      run_wr[c] = wr_i && (addr_i == ADDR_W'(ADR_RUN + c));
      ctl_nv[c] = ctl_t'(wdata_i[CTL_W:1]);
      if (c != 0) ctl_nv[c].chain = 1'b0;
    end
    if (chain) run_wr[1] = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      stop[c]     = run_wr[c] & wdata_i[CMD_STOP];
      start[c]    = run_wr[c] & wdata_i[CMD_START] & ~wdata_i[CMD_STOP];
      start_ld[c] = start[c] & wdata_i[CMD_LOAD];
    end
    wr_ien   = wr_i && (addr_i == ADDR_W'(ADR_IEN));
    wr_ist   = wr_i && (addr_i == ADDR_W'(ADR_IST));
    pend_clr = wr_ist ? wdata_i[N_CH-1:0] : '0;
  end

  // per-channel input conditioning and counters
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    timer_pair_evt #(
      .SYNC_STAGES(SYNC_STAGES)
    ) i_evt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (ext_i[c]),
      .inv_i     (ctl_q[c].inv),
      .sync_en_i (ctl_q[c].sync_en),
      .sel_i     (ctl_q[c].ev_sel),
      .ev_o      (ev_in[c]),
      .rise_o    (rise_in[c])
    );

    timer_pair_cnt #(
      .W(CNT_W)
    ) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load[c]),
      .step_i   (step[c]),
      .up_i     (up_eff[c]),
      .ld_val_i (rld_q[c]),
      .cnt_o    (cnt[c]),
      .end_o    (at_end[c])
    );
  end

  // step sources, cascade routing and wrap detection
  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      tick[c] = ctl_q[c].cnt_mode ? ev_in[c] : (ctl_q[c].src_ext ? rise_in[c] : 1'b1);
    end
    up_eff[0] = ctl_q[0].up;
    step[0]   = run_q[0] & tick[0];
    if (chain) begin
      up_eff[1] = ctl_q[0].up;
      step[1]   = step[0] & at_end[0];
      wrap[0]   = step[0] & at_end[0] & at_end[1];
      wrap[1]   = 1'b0;
      load[1]   = start_ld[0] | wrap[0];
    end else begin
      up_eff[1] = ctl_q[1].up;
      step[1]   = run_q[1] & tick[1];
      wrap[0]   = step[0] & at_end[0];
      wrap[1]   = step[1] & at_end[1];
      load[1]   = start_ld[1] | wrap[1];
    end
    load[0] = start_ld[0] | wrap[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++) begin
        ctl_q[c] <= '0;
        rld_q[c] <= '0;
      end
      run_q  <= '0;
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      for (int c = 0; c < N_CH; c++) begin
        if (wr_ctl[c]) ctl_q[c] <= ctl_nv[c];
        if (wr_rld[c]) rld_q[c] <= wdata_i[CNT_W-1:0];
        if (stop[c])                               run_q[c] <= 1'b0;
        else if (start[c])                         run_q[c] <= 1'b1;
        else if (wrap[c] && ctl_q[c].one_shot)     run_q[c] <= 1'b0;
      end
      if (wr_ien) ien_q <= wdata_i[N_CH-1:0];
      pend_q <= (pend_q & ~pend_clr) | wrap;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == ADDR_W'(ADR_CTL + c)) rdata_o[CTL_W:0]   = {ctl_q[c], run_q[c]};
      if (addr_i == ADDR_W'(ADR_RLD + c)) rdata_o[CNT_W-1:0] = rld_q[c];
      if (addr_i == ADDR_W'(ADR_CNT + c)) rdata_o[CNT_W-1:0] = cnt[c];
    end
    if (addr_i == ADDR_W'(ADR_IEN)) rdata_o[N_CH-1:0] = ien_q;
    if (addr_i == ADDR_W'(ADR_IST)) rdata_o[N_CH-1:0] = pend_q;
  end

  assign irq_o = pend_q & ien_q;

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !start[0]) |=> $stable(cnt[0])); // R4

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ld[0] |=> (cnt[0] == $past(rld_q[0]))); // R4

  AST_WRAP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[0]) |-> $past(run_q[0] && at_end[0])); // R5

  AST_ONE_SHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap[0] && ctl_q[0].one_shot && !run_wr[0]) |=> !run_q[0]); // R6

  AST_CHAIN_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && !pend_q[1]) |=> !pend_q[1]); // R10

endmodule

// File: tb/test_timer_pair.sv
`timescale 1ns/1ps
module test_timer_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  ext = '0;
  logic [1:0]  irq;
  int          n_chk = 0;
  int          n_err = 0;

  localparam logic [3:0] CTL_A = 0, CTL_B = 1, RUN_A = 2, RUN_B = 3;
  localparam logic [3:0] RLD_A = 4, RLD_B = 5, CNT_A = 6, CNT_B = 7, IEN = 8, IST = 9;

  timer_pair i_timer_pair (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .ext_i   (ext),
    .irq_o   (irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic xreg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int ch, input int p, output int hsum);
    hsum = 0;
    for (int i = 0; i < p; i++) begin
      int hi, lo;
      hi = $urandom_range(1, 4);
      lo = $urandom_range(2, 4);
      hsum += hi;
      ext[ch] = 1'b1; idle(hi);
      ext[ch] = 1'b0; idle(lo);
    end
  endtask

  function automatic int exp_down(input int r, input int k);
    return r - (k % (r + 1));
  endfunction

  function automatic int exp_up(input int v, input int k);
    return v + (k % (65536 - v));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int hs, p, r, k, e, ien;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 10; a++) xreg("R1 reset reg", 4'(a), 0);
    check("R1 irq", {30'd0, irq}, 0);

    // R4 stop / resume / stop wins
    wreg(RLD_A, 100);
    xreg("R2 reload readback", RLD_A, 100);
    wreg(RUN_A, 32'h5);
    xreg("R4 start loads", CNT_A, 100);
    idle(10);
    xreg("R3 down per clock", CNT_A, 90);
    xreg("R2 running bit", CTL_A, 32'h1);
    wreg(RUN_A, 32'h2);
    idle(7);
    xreg("R4 stopped holds", CNT_A, 89);
    xreg("R4 running cleared", CTL_A, 0);
    wreg(RUN_A, 32'h1);
    xreg("R4 resume no reload", CNT_A, 89);
    idle(5);
    xreg("R4 resumed count", CNT_A, 84);
    wreg(RUN_A, 32'h3);
    idle(3);
    xreg("R4 stop wins", CNT_A, 83);
    xreg("R4 stop wins run", CTL_A, 0);
    wreg(CTL_A, 32'h1);
    wreg(CNT_A, 32'h55);
    idle(2);
    xreg("R2 bit0 write ignored", CTL_A, 0);
    xreg("R2 count write ignored", CNT_A, 83);
    xreg("R2 run reads zero", RUN_A, 0);

    // R5 R11 underflow, interrupt, clear
    wreg(IEN, 1);
    wreg(RLD_A, 3);
    wreg(RUN_A, 32'h5);
    idle(4);
    xreg("R5 wrap reload", CNT_A, 3);
    xreg("R5 pending", IST, 1);
    check("R11 irq on", {30'd0, irq}, 1);
    xreg("R5 still running", CTL_A, 32'h1);
    wreg(RUN_A, 32'h2);
    wreg(IST, 32'h2);
    xreg("R11 w0 keeps", IST, 1);
    wreg(IST, 32'h1);
    xreg("R11 w1 clears", IST, 0);
    check("R11 irq off", {30'd0, irq}, 0);
    wreg(RUN_A, 32'h5);
    idle(3);
    wreg(IST, 32'h1);
    xreg("R11 set wins clear", IST, 1);
    wreg(RUN_A, 32'h2);
    wreg(IST, 32'h3);

    // R6 one-shot
    wreg(CTL_A, 32'h8);
    wreg(RLD_A, 2);
    wreg(RUN_A, 32'h5);
    idle(3);
    xreg("R6 reload held", CNT_A, 2);
    xreg("R6 stopped", CTL_A, 32'h8);
    xreg("R6 pending", IST, 1);
    idle(5);
    xreg("R6 no further steps", CNT_A, 2);
    wreg(IST, 32'h3);

    // R3 R5 random down / up runs
    for (int it = 0; it < 8; it++) begin
      logic up;
      up  = it[0];
      ien = $urandom_range(0, 3);
      r   = $urandom_range(5, 300);
      k   = $urandom_range(1, 2 * r + 2);
      wreg(RUN_A, 32'h2);
      wreg(IST, 32'h3);
      wreg(IEN, ien);
      wreg(CTL_A, up ? 32'h2 : 32'h0);
      if (up) begin
        wreg(RLD_A, 65535 - r);
        wreg(RUN_A, 32'h5);
        idle(k);
        e = exp_up(65535 - r, k);
        xreg("R5 up count", CNT_A, e);
        xreg("R5 up pending", IST, (k >= r + 1) ? 1 : 0);
        check("R11 irq gate", {30'd0, irq}, ((k >= r + 1) && ien[0]) ? 1 : 0);
      end else begin
        wreg(RLD_A, r);
        wreg(RUN_A, 32'h5);
        idle(k);
        e = exp_down(r, k);
        xreg("R3 down count", CNT_A, e);
        xreg("R5 down pending", IST, (k >= r + 1) ? 1 : 0);
        check("R11 irq gate", {30'd0, irq}, ((k >= r + 1) && ien[0]) ? 1 : 0);
      end
    end
    wreg(RUN_A, 32'h2);
    wreg(IST, 32'h3);
    wreg(IEN, 0);

    // R7 counter mode edge selects on B, synchronized, counting up
    for (int sel = 0; sel < 4; sel++) begin
      p = $urandom_range(1, 6);
      wreg(RUN_B, 32'h2);
      wreg(CTL_B, 32'h106 | (sel << 6));
      wreg(RLD_B, 0);
      idle(4);
      wreg(RUN_B, 32'h5);
      pulses(1, p, hs);
      idle(4);
      case (sel)
        0: e = hs;
        3: e = 2 * p;
        default: e = p;
      endcase
      xreg("R7 edge select", CNT_B, e);
    end

    // R8 invert: pulses then hold high
    p = $urandom_range(2, 6);
    wreg(RUN_B, 32'h2);
    wreg(CTL_B, 32'h146);
    wreg(RLD_B, 0);
    idle(4);
    wreg(RUN_B, 32'h5);
    pulses(1, p, hs);
    ext[1] = 1'b1; idle(4);
    xreg("R8 plain rise", CNT_B, p + 1);
    wreg(RUN_B, 32'h2);
    ext[1] = 1'b0;
    wreg(CTL_B, 32'h166);
    idle(4);
    wreg(RUN_B, 32'h5);
    pulses(1, p, hs);
    ext[1] = 1'b1; idle(4);
    xreg("R8 inverted rise", CNT_B, p);
    wreg(RUN_B, 32'h2);
    ext[1] = 1'b0;

    // R8 synchronizer latency
    wreg(CTL_B, 32'h046);
    idle(4);
    wreg(RUN_B, 32'h5);
    ext[1] = 1'b1; idle(1);
    xreg("R8 unsync one edge", CNT_B, 1);
    wreg(RUN_B, 32'h2);
    ext[1] = 1'b0;
    wreg(CTL_B, 32'h146);
    idle(4);
    wreg(RUN_B, 32'h5);
    ext[1] = 1'b1; idle(1);
    xreg("R8 sync edge1", CNT_B, 0);
    idle(1);
    xreg("R8 sync edge2", CNT_B, 0);
    idle(1);
    xreg("R8 sync edge3", CNT_B, 1);
    wreg(RUN_B, 32'h2);
    ext[1] = 1'b0;
    wreg(IST, 32'h3);

    // R9 timer mode on external clock, A
    p = $urandom_range(2, 8);
    wreg(CTL_A, 32'h302);
    wreg(RLD_A, 0);
    idle(4);
    wreg(RUN_A, 32'h5);
    idle(6);
    xreg("R9 no clocks no steps", CNT_A, 0);
    pulses(0, p, hs);
    idle(4);
    xreg("R9 ext clock count", CNT_A, p);
    wreg(RUN_A, 32'h2);

    // R10 cascade
    wreg(CTL_B, 32'h10);
    xreg("R10 B has no chain bit", CTL_B, 0);
    wreg(CTL_A, 32'h10);
    wreg(RLD_A, 2);
    wreg(RLD_B, 1);
    wreg(IST, 32'h3);
    wreg(RUN_A, 32'h5);
    xreg("R10 load low", CNT_A, 2);
    xreg("R10 load high", CNT_B, 1);
    idle(3);
    xreg("R10 borrow low", CNT_A, 32'hFFFF);
    xreg("R10 borrow high", CNT_B, 0);
    wreg(RUN_B, 32'h2);
    xreg("R10 B cmd ignored", CTL_A, 32'h11);
    xreg("R10 low after ignored stop", CNT_A, 32'hFFFE);
    idle(65534);
    xreg("R10 before wrap", IST, 0);
    idle(1);
    xreg("R10 wrap only A", IST, 1);
    xreg("R10 reload low", CNT_A, 2);
    xreg("R10 reload high", CNT_B, 1);
    wreg(RUN_A, 32'h2);

    summary();
  end

endmodule